// File: doc/BRIEF.md
# Frame Header Decoder and Buffer Size Checker

At the start of every display frame this block reads the leading 16-bit word of the frame buffer and works out how the pixel data that follows it must be fetched. A 3-bit depth code in that word sets the pixel depth. Together with the palette-load mode, the same code sets how many header bytes come before the first pixel. The panel width and height then give the bytes per line and the total frame size. The total is compared against the byte size of the current frame buffer. If the frame does not fit, it is aborted with a sync-error pulse, and the display controller that owns the block clears its enable in response.

The block takes one start strobe per frame. One cycle later it returns a done strobe with exactly one outcome flag:

- accepted, in which case new fetch parameters are loaded;
- skipped, for an unsupported depth or for the mode that loads the palette only;
- sync error.

A subpanel control word can move the first drawn line or shorten the number of lines drawn. The fetch engine, the palette storage and the colour expansion are separate blocks that consume these outputs.

Top module: `frame_hdr_prep`

## Requirements
- R1: While reset is asserted and until the first start, done, accepted, skipped and sync error are all low, and every parameter output is zero.
- R2: A start strobe sampled on a clock edge produces done high for exactly the following cycle. In that cycle exactly one of accepted, skipped or sync error is high. Outside done cycles all three flags are low.
- R3: The depth code is bits 14:12 of the header word. Code 1 gives 2 bits per pixel, code 2 gives 4, code 3 gives 8, and codes 4 to 7 give 16.
- R4: A frame with depth code 0, or with palette-load mode 1, is skipped. It raises no sync error and leaves every parameter output unchanged.
- R5: The data offset is 0 in palette-load mode 2. In modes 0 and 3 it is 512 bytes when the depth code is 3 or more, and 32 bytes otherwise.
- R6: The narrow-format output is 1 only for a 16-bit depth with the TFT input low. It is 0 for any other accepted frame.
- R7: Bytes per line equal (width_m1+1) × bpp / 8, rounded down.
- R8: If offset + floor((width_m1+1)×(height_m1+1)×bpp/8) exceeds buffer size + 2, the frame ends with sync error and the parameter outputs stay unchanged. A frame that lands exactly on buffer size + 2 is accepted.
- R9: When subpanel bit 31 is set and bit 29 is set, the first line is bits 25:16 and the line count is height_m1+1. When bit 31 is set and bit 29 is clear, the first line is 0 and the line count is bits 25:16. When bit 31 is clear, the first line is 0 and the line count is height_m1+1.
- R10: The size check of R8 always uses the full panel height, even when the subpanel word shortens the line count.
- R11: The parameter outputs change only in a cycle in which accepted is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Frame start strobe |
| pal_word_i | input | 16 | First header word; bits 14:12 hold the depth code |
| load_mode_i | input | 2 | Palette-load mode |
| tft_i | input | 1 | Active-matrix panel flag; selects the 16-bit format |
| width_m1_i | input | 10 | Panel width minus one |
| height_m1_i | input | 10 | Panel height minus one |
| subpanel_i | input | 32 | Subpanel control word |
| buf_bytes_i | input | 24 | Byte size of the current frame buffer |
| done_o | output | 1 | Result strobe, one cycle after start |
| frame_ok_o | output | 1 | Frame accepted, parameters updated |
| frame_skip_o | output | 1 | Frame skipped |
| sync_err_o | output | 1 | Size overrun; frame aborted |
| bpp_o | output | 5 | Bits per pixel |
| narrow_o | output | 1 | 16-bit depth uses the 12-bit colour format |
| data_off_o | output | 10 | Byte offset of pixel data |
| line_bytes_o | output | 12 | Bytes per line |
| first_line_o | output | 10 | First line to draw |
| line_count_o | output | 11 | Number of lines to draw |

## Verification
The hardest cases to reach from the ports are the exact size boundary and the shortened subpanel during an overrun. Reaching the boundary takes a width, height and buffer size chosen so that the required bytes equal buffer size + 2, and then a second frame one byte smaller. In the subpanel case, a line count that would fit has to be paired with a full panel that does not. The vector table places rejected and skipped frames straight after accepted ones with different parameters, so that any leak into the held outputs shows up as a miscompare.

// File: rtl/frame_hdr_pkg.sv
package frame_hdr_pkg;

  localparam int OFF_W = 10;

  localparam logic [1:0] LM_HALT      = 2'd1;
  localparam logic [1:0] LM_DATA_ONLY = 2'd2;

  localparam logic [OFF_W-1:0] HDR_LONG  = OFF_W'(512);
  localparam logic [OFF_W-1:0] HDR_SHORT = OFF_W'(32);

  localparam int SP_EN_BIT    = 31;
  localparam int SP_FIRST_BIT = 29;
  localparam int SP_LINE_LSB  = 16;

  typedef enum logic [1:0] {
    RES_NONE = 2'd0,
    RES_OK   = 2'd1,
    RES_SKIP = 2'd2,
    RES_ERR  = 2'd3
  } result_e;

endpackage

// File: rtl/fhp_depth_decode.sv
module fhp_depth_decode
  import frame_hdr_pkg::*;
(
  input  logic [2:0]       code_i,
  input  logic [1:0]       load_mode_i,
  input  logic             tft_i,
  output logic             supported_o,
  output logic [2:0]       bpp_lg_o,
  output logic [4:0]       bpp_o,
  output logic [OFF_W-1:0] off_o,
  output logic             narrow_o
);

  always_comb begin
    supported_o = (code_i != 3'd0);
    unique case (code_i)
      3'd1:    bpp_lg_o = 3'd1;
      3'd2:    bpp_lg_o = 3'd2;
      3'd3:    bpp_lg_o = 3'd3;
      3'd0:    bpp_lg_o = 3'd0;
      default: bpp_lg_o = 3'd4;
    endcase
    bpp_o    = 5'(1) << bpp_lg_o;
    narrow_o = (bpp_lg_o == 3'd4) && !tft_i;
    if (load_mode_i == LM_DATA_ONLY)
      off_o = '0;
    else if (code_i >= 3'd3)
      off_o = HDR_LONG;
    else
      off_o = HDR_SHORT;
  end

endmodule

// File: rtl/fhp_geometry.sv
module fhp_geometry
  import frame_hdr_pkg::*;
#(
  parameter int DIM_W = 10,
  parameter int BUF_W = 24
) (
  input  logic [DIM_W-1:0]   width_m1_i,
  input  logic [DIM_W-1:0]   height_m1_i,
  input  logic [2:0]         bpp_lg_i,
  input  logic [OFF_W-1:0]   off_i,
  input  logic [31:0]        subpanel_i,
  input  logic [BUF_W-1:0]   buf_bytes_i,
  output logic [DIM_W+1:0]   line_bytes_o,
  output logic [DIM_W-1:0]   first_line_o,
  output logic [DIM_W:0]     line_count_o,
  output logic               overrun_o
);

  localparam int EXT_W   = DIM_W + 1;
  localparam int LBB_W   = EXT_W + 4;
  localparam int AREA_W  = 2 * EXT_W;
  localparam int FBITS_W = AREA_W + 4;
  localparam int FRAME_W = FBITS_W - 3;
  localparam int CMP_W   = ((FRAME_W > BUF_W) ? FRAME_W : BUF_W) + 2;

  logic [EXT_W-1:0]   width;
  logic [EXT_W-1:0]   height;
  logic [LBB_W-1:0]   line_bits;
  logic [AREA_W-1:0]  area;
  logic [FBITS_W-1:0] frame_bits;
  logic [CMP_W-1:0]   need;
  logic [CMP_W-1:0]   limit;
  logic [DIM_W-1:0]   sp_value;

  always_comb begin
    width      = EXT_W'(width_m1_i) + EXT_W'(1);
    height     = EXT_W'(height_m1_i) + EXT_W'(1);
    line_bits  = LBB_W'(width) << bpp_lg_i;
    line_bytes_o = line_bits[LBB_W-1:3];
    area       = AREA_W'(width) * AREA_W'(height);
    frame_bits = FBITS_W'(area) << bpp_lg_i;
    need       = CMP_W'(off_i) + CMP_W'(frame_bits[FBITS_W-1:3]);
    limit      = CMP_W'(buf_bytes_i) + CMP_W'(2);
    overrun_o  = need > limit;
  end

  always_comb begin
    sp_value     = subpanel_i[SP_LINE_LSB +: DIM_W];
    first_line_o = '0;
    line_count_o = height;
    if (subpanel_i[SP_EN_BIT]) begin
      if (subpanel_i[SP_FIRST_BIT])
        first_line_o = sp_value;
      else
        line_count_o = EXT_W'(sp_value);
    end
  end

endmodule

// File: rtl/frame_hdr_prep.sv
module frame_hdr_prep
  import frame_hdr_pkg::*;
#(
  parameter int DIM_W = 10,
  parameter int BUF_W = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [15:0]         pal_word_i,
  input  logic [1:0]          load_mode_i,
  input  logic                tft_i,
  input  logic [DIM_W-1:0]    width_m1_i,
  input  logic [DIM_W-1:0]    height_m1_i,
  input  logic [31:0]         subpanel_i,
  input  logic [BUF_W-1:0]    buf_bytes_i,
  output logic                done_o,
  output logic                frame_ok_o,
  output logic                frame_skip_o,
  output logic                sync_err_o,
  output logic [4:0]          bpp_o,
  output logic                narrow_o,
  output logic [OFF_W-1:0]    data_off_o,
  output logic [DIM_W+1:0]    line_bytes_o,
  output logic [DIM_W-1:0]    first_line_o,
  output logic [DIM_W:0]      line_count_o
);

  localparam int CODE_LSB = 12;

  logic             dec_supported;
  logic [2:0]       dec_bpp_lg;
  logic [4:0]       dec_bpp;
  logic [OFF_W-1:0] dec_off;
  logic             dec_narrow;
  logic [DIM_W+1:0] geo_line_bytes;
  logic [DIM_W-1:0] geo_first;
  logic [DIM_W:0]   geo_count;
  logic             geo_overrun;

  fhp_depth_decode u_depth (
    .code_i      (pal_word_i[CODE_LSB +: 3]),
    .load_mode_i (load_mode_i),
    .tft_i       (tft_i),
    .supported_o (dec_supported),
    .bpp_lg_o    (dec_bpp_lg),
    .bpp_o       (dec_bpp),
    .off_o       (dec_off),
    .narrow_o    (dec_narrow)
  );

  fhp_geometry #(.DIM_W(DIM_W), .BUF_W(BUF_W)) u_geom (
    .width_m1_i   (width_m1_i),
    .height_m1_i  (height_m1_i),
    .bpp_lg_i     (dec_bpp_lg),
    .off_i        (dec_off),
    .subpanel_i   (subpanel_i),
    .buf_bytes_i  (buf_bytes_i),
    .line_bytes_o (geo_line_bytes),
    .first_line_o (geo_first),
    .line_count_o (geo_count),
    .overrun_o    (geo_overrun)
  );

  result_e res_d, res_q;
  logic    load_en;

  // next-state
  always_comb begin
    res_d = RES_NONE;
    if (start_i) begin
      if (load_mode_i == LM_HALT || !dec_supported)
        res_d = RES_SKIP;
      else if (geo_overrun)
        res_d = RES_ERR;
      else
        res_d = RES_OK;
    end
    load_en = (res_d == RES_OK);
  end

  // result register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) res_q <= RES_NONE;
    else        res_q <= res_d;
  end

  // parameter registers with explicit load enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bpp_o        <= '0;
      narrow_o     <= 1'b0;
      data_off_o   <= '0;
      line_bytes_o <= '0;
      first_line_o <= '0;
      line_count_o <= '0;
    end else if (load_en) begin
      bpp_o        <= dec_bpp;
      narrow_o     <= dec_narrow;
      data_off_o   <= dec_off;
      line_bytes_o <= geo_line_bytes;
      first_line_o <= geo_first;
      line_count_o <= geo_count;
    end
  end

  always_comb begin
    done_o       = (res_q != RES_NONE);
    frame_ok_o   = (res_q == RES_OK);
    frame_skip_o = (res_q == RES_SKIP);
    sync_err_o   = (res_q == RES_ERR);
  end

  AST_DONE_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> done_o); // R2
  AST_DONE_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(start_i)); // R2
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ($countones({frame_ok_o, frame_skip_o, sync_err_o}) == 1)); // R2
  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> !(frame_ok_o || frame_skip_o || sync_err_o)); // R2
  AST_HOLD_PARAMS: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_ok_o |-> ($stable(bpp_o) && $stable(data_off_o) && $stable(line_bytes_o)
                     && $stable(first_line_o) && $stable(line_count_o)
                     && $stable(narrow_o))); // R11
  AST_BPP_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ok_o |-> ($onehot(bpp_o) && bpp_o >= 5'd2)); // R3
  AST_NARROW_16: assert property (@(posedge clk) disable iff (!rst_n)
    narrow_o |-> (bpp_o == 5'd16)); // R6

endmodule

// File: tb/test_frame_hdr_prep.sv
module test_frame_hdr_prep;

  typedef struct packed {
    logic [2:0]  code;
    logic [1:0]  mode;
    logic        tft;
    logic [9:0]  wm1;
    logic [9:0]  hm1;
    logic [31:0] sub;
    logic [23:0] bufsz;
    logic [1:0]  res;   // 0 accepted, 1 skipped, 2 sync error
    logic [4:0]  bpp;
    logic [9:0]  off;
    logic [11:0] lb;
    logic [9:0]  first;
    logic [10:0] cnt;
    logic        narrow;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VT [NV] = '{
    // R3 R7 2 bpp, short header
    '{3'd1, 2'd0, 1'b0, 10'd99,  10'd49,  32'h0,         24'd100000, 2'd0, 5'd2,  10'd32,  12'd25,  10'd0, 11'd50,  1'b0, 4'd3},
    // R9 subpanel replaces height, mode 3
    '{3'd2, 2'd3, 1'b1, 10'd63,  10'd9,   32'h8005_0000, 24'd5000,   2'd0, 5'd4,  10'd32,  12'd32,  10'd0, 11'd5,   1'b0, 4'd9},
    // R5 long header, R9 first line
    '{3'd3, 2'd0, 1'b0, 10'd15,  10'd15,  32'hA003_0000, 24'd1000,   2'd0, 5'd8,  10'd512, 12'd16,  10'd3, 11'd16,  1'b0, 4'd5},
    // R8 exactly at limit, R6 narrow, R5 mode 2
    '{3'd5, 2'd2, 1'b0, 10'd319, 10'd239, 32'h0,         24'd153598, 2'd0, 5'd16, 10'd0,   12'd640, 10'd0, 11'd240, 1'b1, 4'd8},
    // R8 one byte short
    '{3'd5, 2'd2, 1'b0, 10'd319, 10'd239, 32'h0,         24'd153597, 2'd2, 5'd0,  10'd0,   12'd0,   10'd0, 11'd0,   1'b0, 4'd8},
    // R6 wide 16-bit with TFT
    '{3'd7, 2'd0, 1'b1, 10'd7,   10'd3,   32'h0,         24'd600,    2'd0, 5'd16, 10'd512, 12'd16,  10'd0, 11'd4,   1'b0, 4'd6},
    // R4 code 0
    '{3'd0, 2'd0, 1'b0, 10'd7,   10'd3,   32'h0,         24'd600,    2'd1, 5'd0,  10'd0,   12'd0,   10'd0, 11'd0,   1'b0, 4'd4},
    // R4 palette-only mode
    '{3'd3, 2'd1, 1'b0, 10'd1,   10'd1,   32'h0,         24'd9000,   2'd1, 5'd0,  10'd0,   12'd0,   10'd0, 11'd0,   1'b0, 4'd4},
    // R8 tiny frame overruns small buffer
    '{3'd4, 2'd0, 1'b0, 10'd0,   10'd0,   32'h0,         24'd511,    2'd2, 5'd0,  10'd0,   12'd0,   10'd0, 11'd0,   1'b0, 4'd8},
    // R7 line bytes round down to 0
    '{3'd1, 2'd0, 1'b0, 10'd0,   10'd0,   32'h0,         24'd30,     2'd0, 5'd2,  10'd32,  12'd0,   10'd0, 11'd1,   1'b0, 4'd7},
    // R10 short subpanel does not rescue overrun
    '{3'd3, 2'd2, 1'b0, 10'd99,  10'd99,  32'h8001_0000, 24'd9997,   2'd2, 5'd0,  10'd0,   12'd0,   10'd0, 11'd0,   1'b0, 4'd10},
    // R9 bit 29 alone without enable is ignored
    '{3'd2, 2'd0, 1'b0, 10'd7,   10'd19,  32'h2007_0000, 24'd1000,   2'd0, 5'd4,  10'd32,  12'd4,   10'd0, 11'd20,  1'b0, 4'd9}
  };

  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic [15:0] pal_word_i;
  logic [1:0]  load_mode_i;
  logic        tft_i;
  logic [9:0]  width_m1_i;
  logic [9:0]  height_m1_i;
  logic [31:0] subpanel_i;
  logic [23:0] buf_bytes_i;
  logic        done_o, frame_ok_o, frame_skip_o, sync_err_o;
  logic [4:0]  bpp_o;
  logic        narrow_o;
  logic [9:0]  data_off_o;
  logic [11:0] line_bytes_o;
  logic [9:0]  first_line_o;
  logic [10:0] line_count_o;

  frame_hdr_prep i_frame_hdr_prep (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .pal_word_i(pal_word_i),
    .load_mode_i(load_mode_i), .tft_i(tft_i), .width_m1_i(width_m1_i),
    .height_m1_i(height_m1_i), .subpanel_i(subpanel_i), .buf_bytes_i(buf_bytes_i),
    .done_o(done_o), .frame_ok_o(frame_ok_o), .frame_skip_o(frame_skip_o),
    .sync_err_o(sync_err_o), .bpp_o(bpp_o), .narrow_o(narrow_o),
    .data_off_o(data_off_o), .line_bytes_o(line_bytes_o),
    .first_line_o(first_line_o), .line_count_o(line_count_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic check_params(input string req, input vec_t e);
    check(req, "bpp",        32'(bpp_o),        32'(e.bpp));
    check(req, "narrow",     32'(narrow_o),     32'(e.narrow));
    check(req, "offset",     32'(data_off_o),   32'(e.off));
    check(req, "line bytes", 32'(line_bytes_o), 32'(e.lb));
    check(req, "first line", 32'(first_line_o), 32'(e.first));
    check(req, "line count", 32'(line_count_o), 32'(e.cnt));
  endtask

  initial begin
    #400000;
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    vec_t held;
    string tag;
    held = '0;
    rst_n = 1'b0; start_i = 1'b0; pal_word_i = '0; load_mode_i = '0; tft_i = 1'b0;
    width_m1_i = '0; height_m1_i = '0; subpanel_i = '0; buf_bytes_i = '0;
    repeat (3) @(negedge clk);
    // R1 during reset
    check("R1", "flags in reset", 32'({done_o, frame_ok_o, frame_skip_o, sync_err_o}), 32'h0);
    check_params("R1", held);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R1", "flags after reset", 32'({done_o, frame_ok_o, frame_skip_o, sync_err_o}), 32'h0);
    check_params("R1", held);

    for (int i = 0; i < NV; i++) begin
      tag = $sformatf("R%0d vec%0d", VT[i].req, i);
      pal_word_i  = {1'b1, VT[i].code, 12'hA5C};
      load_mode_i = VT[i].mode;
      tft_i       = VT[i].tft;
      width_m1_i  = VT[i].wm1;
      height_m1_i = VT[i].hm1;
      subpanel_i  = VT[i].sub;
      buf_bytes_i = VT[i].bufsz;
      start_i     = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      // R2 result one cycle after start
      check(tag, "done", 32'(done_o), 32'h1);
      check(tag, "ok",   32'(frame_ok_o),   32'(VT[i].res == 2'd0));
      check(tag, "skip", 32'(frame_skip_o), 32'(VT[i].res == 2'd1));
      check(tag, "err",  32'(sync_err_o),   32'(VT[i].res == 2'd2));
      if (VT[i].res == 2'd0) held = VT[i];
      // R11 params held on skip and error
      check_params(tag, held);
      @(negedge clk);
      check("R2", "done pulse width", 32'({done_o, frame_ok_o, frame_skip_o, sync_err_o}), 32'h0);
      check_params("R11", held);
    end

    // R2 back-to-back starts: two done strobes in a row
    pal_word_i = 16'h1000; load_mode_i = 2'd0; width_m1_i = 10'd7; height_m1_i = 10'd7;
    subpanel_i = '0; buf_bytes_i = 24'd100; start_i = 1'b1;
    @(negedge clk);
    check("R2", "b2b first done", 32'({done_o, frame_ok_o}), 32'h3);
    pal_word_i = 16'h0000;
    @(negedge clk);
    start_i = 1'b0;
    check("R2", "b2b second skip", 32'({done_o, frame_skip_o}), 32'h3);
    // R4 skipped frame kept the parameters from the first (w8, 2 bpp -> 2 bytes/line)
    check("R4", "line bytes after skip", 32'(line_bytes_o), 32'd2);
    @(negedge clk);
    check("R2", "idle after b2b", 32'(done_o), 32'h0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule